// File: doc/BRIEF.md
# Initiator Port Access Firewall

This block guards the path from a single bus initiator to eight downstream targets. Every request address is mapped onto one of eight fixed, non-overlapping windows. The request is then checked against a per-target permission mask and against a rule that keeps bursts off the three peripheral-side targets. It is either steered to exactly one target or refused on the spot. A refused access raises an abort toward the initiator and leaves a sticky cause bit in a status word. Reading that status word through the register port empties it.

An exclusive-read command is never passed downstream as such. The target sees an ordinary read, and a lock line is raised toward the targets. The lock stays up until a write to the same address has been accepted. The register port is a simple select/read/write interface. Read data is combinational, and all register updates take effect at the rising clock edge.

Target windows: target k covers `BASE + k*2^WIN_BITS` up to `BASE + (k+1)*2^WIN_BITS - 1`, for k = 0..7. With the defaults `BASE = 0x1000_0000` and `WIN_BITS = 20`, target k starts at `0x1000_0000 + k*0x10_0000`.

Top module: `fw_firewall`

## Requirements
- R1: A valid request whose address falls in window k, is permitted, and is not a refused burst drives `tgt_sel` one-hot with bit k set, in the same cycle. `tgt_addr` carries the request address and `tgt_cmd` is 1 only for a write (`req_cmd` = 2'b01). An address outside all eight windows issues no target select and sets cause bit 0 (decode error).
- R2: Permission bit k (mask bit positions: 0 slow external memory, 1 fast external memory, 2 on-chip memory 1, 3 on-chip memory 2, 4 multibank on-chip memory, 5 private peripheral bus, 6 public peripheral bus, 7 processor peripheral interface) set to 1 refuses any access to target k and sets cause bit 2 (protected area).
- R3: A burst request (`req_burst` = 1) to target 5, 6 or 7 is refused and sets cause bit 3. Only one cause is recorded per refused access, with priority decode error over protection over burst. A forwarded burst drives `tgt_burst` = 1.
- R4: `tgt_abort` from a target sets cause bit 1 at the next clock edge and also drives `req_abort` in the same cycle.
- R5: Reading the abort-type register (`reg_sel` = 1, `reg_rd` = 1) returns the cause bits in `reg_rdata[3:0]` with bits 31:4 zero, and clears them at that clock edge. A cause raised in the same cycle as the read is kept. Cause bits otherwise stay set until read.
- R6: A write with `reg_sel` = 1 changes neither the cause bits nor the permission mask.
- R7: After reset, the permission mask reads 8'hFF, so every target is refused, and the cause bits read 0.
- R8: An accepted exclusive read (`req_cmd` = 2'b10) is issued as a read (`tgt_cmd` = 0) with `tgt_lock` = 1. `tgt_lock` stays 1 in every later cycle up to and including the cycle of the first accepted write to the same address, and is 0 from the next cycle on.
- R9: A write with `reg_sel` = 0 loads the permission mask from `reg_wdata[7:0]`. A read with `reg_sel` = 0 returns the mask in bits 7:0 with bits 31:8 zero.
- R10: A refused request drives `req_abort` = 1 and `tgt_sel` = 0 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Initiator request present |
| req_cmd | input | 2 | 00 read, 01 write, 10 exclusive read, 11 treated as read |
| req_addr | input | 32 | Request address |
| req_burst | input | 1 | Request is a burst |
| req_abort | output | 1 | Request refused or target reported an abort |
| tgt_sel | output | 8 | One-hot target select |
| tgt_cmd | output | 1 | 1 write, 0 read |
| tgt_addr | output | 32 | Address toward targets |
| tgt_burst | output | 1 | Forwarded burst |
| tgt_lock | output | 1 | Lock toward targets |
| tgt_abort | input | 1 | Abort reported by the accessed target |
| reg_sel | input | 1 | 0 permission mask, 1 abort-type register |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |

## Verification
Directed accesses run through each window, just below and just above the decoded range, and combine a protected target with a burst. These cases separate the decode, protection and burst causes and check their priority. Exclusive-read sequences are tried with a non-matching write first and then a matching one, which shows that the lock is tied to the address. Constrained-random traffic then mixes random permission masks, commands, bursts, target aborts and status reads, some of them in the same cycle as a new abort. It writes back to the locked address often, so that the sticky-versus-clear behaviour and the lock release are both exercised under many interleavings.

// File: rtl/fw_pkg.sv
package fw_pkg;
    localparam int NTGT  = 8;
    localparam int NCAUS = 4;

    typedef enum logic [1:0] {
        CMD_RD  = 2'b00,
        CMD_WR  = 2'b01,
        CMD_RDX = 2'b10,
        CMD_RSV = 2'b11
    } cmd_e;

    localparam int C_DEC   = 0;
    localparam int C_TGT   = 1;
    localparam int C_PROT  = 2;
    localparam int C_BURST = 3;

    localparam logic [NTGT-1:0] BURST_BLOCK = 8'hE0;

    typedef struct packed {
        logic        valid;
        logic        is_wr;
        logic        is_rdx;
        logic        burst;
        logic [31:0] addr;
    } req_t;

    function automatic req_t unpack_req(logic v, logic [1:0] c, logic b, logic [31:0] a);
        req_t r;
        r.valid  = v;
        r.is_wr  = (cmd_e'(c) == CMD_WR);
        r.is_rdx = (cmd_e'(c) == CMD_RDX);
        r.burst  = b;
        r.addr   = a;
        return r;
    endfunction
endpackage

// File: rtl/fw_decode.sv
module fw_decode #(
    parameter int          AW       = 32,
    parameter int          NT       = 8,
    parameter int          WIN_BITS = 20,
    parameter logic [31:0] BASE     = 32'h1000_0000
) (
    input  logic [AW-1:0] addr,
    output logic [NT-1:0] hit,
    output logic          miss
);
    localparam int IDXW = $clog2(NT);

    logic [AW-1:0] off;
    logic          in_range;

    always_comb begin
        off      = addr - BASE[AW-1:0];
        in_range = (off >> WIN_BITS) < AW'(NT);
        miss     = !in_range;
    end

    for (genvar k = 0; k < NT; k++) begin : g_hit
        assign hit[k] = in_range && (off[WIN_BITS +: IDXW] == IDXW'(k));
    end
endmodule

// File: rtl/fw_gate.sv
module fw_gate
    import fw_pkg::*;
#(
    parameter int NT = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          valid,
    input  logic          burst,
    input  logic [NT-1:0] hit,
    input  logic          miss,
    input  logic [NT-1:0] prot,
    output logic [NT-1:0] fwd,
    output logic [NCAUS-1:0] cause
);
    always_comb begin
        fwd   = '0;
        cause = '0;
        if (valid) begin
            if (miss)
                cause[C_DEC] = 1'b1;
            else if (|(hit & prot))
                cause[C_PROT] = 1'b1;
            else if (burst && |(hit & BURST_BLOCK[NT-1:0]))
                cause[C_BURST] = 1'b1;
            else
                fwd = hit;
        end
    end

    p_no_prot_fwd_r2: assert property (@(posedge clk) disable iff (rst)
        (|fwd) |-> !(|(fwd & prot)));
    p_one_cause_r3: assert property (@(posedge clk) disable iff (rst)
        (|cause) |-> (fwd == '0));
endmodule

// File: rtl/fw_lock.sv
module fw_lock #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          acc,
    input  logic          is_rdx,
    input  logic          is_wr,
    input  logic [AW-1:0] addr,
    output logic          lock
);
    logic          lock_q;
    logic [AW-1:0] lock_addr_q;
    logic          release_now;

    assign release_now = acc && is_wr && lock_q && (addr == lock_addr_q);
    assign lock        = lock_q || (acc && is_rdx);

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q      <= 1'b0;
            lock_addr_q <= '0;
        end else if (acc && is_rdx) begin
            lock_q      <= 1'b1;
            lock_addr_q <= addr;
        end else if (release_now) begin
            lock_q      <= 1'b0;
        end
    end

    p_lock_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (lock_q && !(acc && is_wr)) |=> lock_q);
endmodule

// File: rtl/fw_regs.sv
module fw_regs
    import fw_pkg::*;
#(
    parameter int NT = 8,
    parameter int DW = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_sel,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [DW-1:0]    reg_wdata,
    input  logic [NCAUS-1:0] new_cause,
    output logic [NT-1:0]    prot,
    output logic [DW-1:0]    reg_rdata
);
    logic [NCAUS-1:0] sts_q;
    logic             rd_sts;

    assign rd_sts = reg_rd && reg_sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            prot  <= '1;
            sts_q <= '0;
        end else begin
            if (reg_wr && !reg_sel)
                prot <= reg_wdata[NT-1:0];
            sts_q <= (rd_sts ? '0 : sts_q) | new_cause;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_sel) reg_rdata[NCAUS-1:0] = sts_q;
        else         reg_rdata[NT-1:0]    = prot;
    end

    p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        !rd_sts |=> ((sts_q & $past(sts_q)) == $past(sts_q)));
    p_wr_ignored_r6: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_sel && !reg_rd && new_cause == '0) |=>
        (sts_q == $past(sts_q) && prot == $past(prot)));
endmodule

// File: rtl/fw_firewall.sv
module fw_firewall
    import fw_pkg::*;
#(
    parameter int          WIN_BITS = 20,
    parameter logic [31:0] BASE     = 32'h1000_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [1:0]  req_cmd,
    input  logic [31:0] req_addr,
    input  logic        req_burst,
    output logic        req_abort,
    output logic [7:0]  tgt_sel,
    output logic        tgt_cmd,
    output logic [31:0] tgt_addr,
    output logic        tgt_burst,
    output logic        tgt_lock,
    input  logic        tgt_abort,
    input  logic        reg_sel,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata
);
    req_t             rq;
    logic [NTGT-1:0]  hit, fwd, prot;
    logic             miss;
    logic [NCAUS-1:0] cause, new_cause;

    assign rq = unpack_req(req_valid, req_cmd, req_burst, req_addr);

    fw_decode #(.AW(32), .NT(NTGT), .WIN_BITS(WIN_BITS), .BASE(BASE)) u_dec (
        .addr(rq.addr), .hit(hit), .miss(miss));

    fw_gate #(.NT(NTGT)) u_gate (
        .clk(clk), .rst(rst), .valid(rq.valid), .burst(rq.burst),
        .hit(hit), .miss(miss), .prot(prot), .fwd(fwd), .cause(cause));

    fw_lock #(.AW(32)) u_lock (
        .clk(clk), .rst(rst), .acc(|fwd), .is_rdx(rq.is_rdx),
        .is_wr(rq.is_wr), .addr(rq.addr), .lock(tgt_lock));

    always_comb begin
        new_cause        = cause;
        new_cause[C_TGT] = tgt_abort;
    end

    fw_regs #(.NT(NTGT), .DW(32)) u_regs (
        .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .new_cause(new_cause),
        .prot(prot), .reg_rdata(reg_rdata));

    assign tgt_sel   = fwd;
    assign tgt_cmd   = rq.is_wr;
    assign tgt_addr  = rq.addr;
    assign tgt_burst = rq.burst && (|fwd);
    assign req_abort = (|cause) || tgt_abort;

    p_sel_onehot_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(tgt_sel));
    p_burst_block_r3: assert property (@(posedge clk) disable iff (rst)
        tgt_burst |-> (tgt_sel[7:5] == 3'b000));
    p_no_fwd_on_abort_r10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_abort && !tgt_abort) |-> (tgt_sel == 8'h00));
endmodule

// File: tb/test_fw_firewall.sv
`timescale 1ns/1ps
module test_fw_firewall;
    localparam logic [31:0] BASE = 32'h1000_0000;
    localparam int          WB   = 20;

    logic clk = 0, rst = 1;
    logic req_valid = 0, req_burst = 0, tgt_abort = 0;
    logic [1:0] req_cmd = 0;
    logic [31:0] req_addr = 0, reg_wdata = 0;
    logic reg_sel = 0, reg_wr = 0, reg_rd = 0;
    logic req_abort, tgt_cmd, tgt_burst, tgt_lock;
    logic [7:0] tgt_sel;
    logic [31:0] tgt_addr, reg_rdata;

    int checks = 0, fails = 0;
    logic [7:0]  m_prot;
    logic [3:0]  m_sts;
    logic        m_lock;
    logic [31:0] m_laddr;

    always #2 clk = ~clk;

    fw_firewall #(.WIN_BITS(WB), .BASE(BASE)) i_fw_firewall (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_addr(req_addr), .req_burst(req_burst), .req_abort(req_abort),
        .tgt_sel(tgt_sel), .tgt_cmd(tgt_cmd), .tgt_addr(tgt_addr),
        .tgt_burst(tgt_burst), .tgt_lock(tgt_lock), .tgt_abort(tgt_abort),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

    function automatic int tgt_of(logic [31:0] a);
        logic [31:0] o = a - BASE;
        if ((o >> WB) < 8) return int'(o >> WB);
        return -1;
    endfunction

    function automatic logic [3:0] cause_of(logic v, logic [31:0] a, logic b, logic [7:0] p);
        int t = tgt_of(a);
        if (!v) return 4'b0000;
        if (t < 0) return 4'b0001;
        if (p[t]) return 4'b0100;
        if (b && t >= 5) return 4'b1000;
        return 4'b0000;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] waddr(int t);
        return BASE + (32'(t) << WB) + ($urandom & 32'h000F_FFFC);
    endfunction

    task automatic step(logic v, logic [1:0] c, logic [31:0] a, logic b, logic te,
                        logic s, logic w, logic r, logic [31:0] wd, string tag);
        logic [3:0] cz;
        logic [7:0] es;
        logic acc, el;
        @(negedge clk);
        req_valid = v; req_cmd = c; req_addr = a; req_burst = b; tgt_abort = te;
        reg_sel = s; reg_wr = w; reg_rd = r; reg_wdata = wd;
        #1;
        cz  = cause_of(v, a, b, m_prot);
        acc = v && (cz == 0);
        es  = acc ? (8'h01 << tgt_of(a)) : 8'h00;
        el  = m_lock || (acc && c == 2'b10);
        chk({tag, " R1 sel"}, 32'(tgt_sel), 32'(es));
        chk({tag, " R10 abort"}, 32'(req_abort), 32'((cz != 0) || te));
        chk({tag, " R8 lock"}, 32'(tgt_lock), 32'(el));
        chk({tag, " R5/R9 rdata"}, reg_rdata, s ? {28'h0, m_sts} : {24'h0, m_prot});
        if (acc) begin
            chk({tag, " R1 cmd"}, 32'(tgt_cmd), 32'(c == 2'b01));
            chk({tag, " R3 burst"}, 32'(tgt_burst), 32'(b));
            chk({tag, " R1 addr"}, tgt_addr, a);
        end
        @(posedge clk);
        m_sts = ((r && s) ? 4'h0 : m_sts) | cz | {2'b00, te, 1'b0};
        if (w && !s) m_prot = wd[7:0];
        if (acc && c == 2'b10) begin m_lock = 1; m_laddr = a; end
        else if (acc && c == 2'b01 && m_lock && a == m_laddr) m_lock = 0;
    endtask

    task automatic idle(string tag);
        step(0, 0, 0, 0, 0, 1, 0, 0, 0, tag);
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog: actual running expected done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        m_prot = 8'hFF; m_sts = 0; m_lock = 0; m_laddr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        #1;
        chk("R7 reset mask", reg_rdata, 32'h0000_00FF);
        reg_sel = 1; #1;
        chk("R7 reset status", reg_rdata, 32'h0);
        // R7/R2: all targets refused after reset
        step(1, 2'b00, waddr(3), 0, 0, 1, 0, 0, 0, "R2 refused at reset");
        step(0, 0, 0, 0, 0, 1, 0, 1, 0, "R5 read clears");
        idle("R5 after clear");
        // R9: open every target, upper bits ignored
        step(0, 0, 0, 0, 0, 0, 1, 0, 32'hFFFF_FF00, "R9 write mask");
        idle("R9 readback");
        for (int t = 0; t < 8; t++) step(1, 2'b00, waddr(t), 0, 0, 1, 0, 0, 0, "R1 window");
        step(1, 2'b01, BASE - 4, 0, 0, 1, 0, 0, 0, "R1 below range");
        step(1, 2'b00, BASE + 32'h0080_0000, 0, 0, 1, 0, 0, 0, "R1 above range");
        // R3: burst to 5..7 refused, to 0..4 allowed
        step(1, 2'b00, waddr(6), 1, 0, 1, 0, 1, 0, "R3 burst refused");
        step(1, 2'b00, waddr(4), 1, 0, 1, 0, 0, 0, "R3 burst allowed");
        // R3 priority: protection over burst
        step(0, 0, 0, 0, 0, 0, 1, 0, 32'h80, "R2 protect 7");
        step(1, 2'b00, waddr(7), 1, 0, 1, 0, 1, 0, "R3 priority protect");
        idle("R3 priority status");
        // R4 target abort, and same-cycle new abort survives read (R5)
        step(0, 0, 0, 0, 1, 1, 0, 0, 0, "R4 target abort");
        step(1, 2'b00, BASE - 4, 0, 0, 1, 0, 1, 0, "R5 read with new abort");
        idle("R5 survivor");
        // R6: write to abort register ignored
        step(0, 0, 0, 0, 0, 1, 1, 0, 32'hFFFF_FFFF, "R6 write ignored");
        idle("R6 readback");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R6 mask kept");
        // R8 exclusive read, non-matching then matching write
        step(1, 2'b10, BASE + 32'h0010_0040, 0, 0, 1, 0, 1, 0, "R8 excl read");
        step(1, 2'b01, BASE + 32'h0010_0044, 0, 0, 1, 0, 0, 0, "R8 other write");
        step(1, 2'b00, BASE + 32'h0020_0000, 0, 0, 1, 0, 0, 0, "R8 hold");
        step(1, 2'b01, BASE + 32'h0010_0040, 0, 0, 1, 0, 0, 0, "R8 matching write");
        idle("R8 released");
        // random traffic
        for (int i = 0; i < 3000; i++) begin
            int t = $urandom_range(0, 9);
            logic [31:0] a = (t < 8) ? waddr(t) : (($urandom & 1) ? BASE - 32'h100 : BASE + 32'h0090_0000);
            logic [1:0] c = 2'($urandom_range(0, 3));
            if (m_lock && $urandom_range(0, 3) == 0) begin a = m_laddr; c = 2'b01; end
            step($urandom_range(0, 4) != 0, c, a, $urandom_range(0, 3) == 0,
                 $urandom_range(0, 15) == 0, 1'($urandom), $urandom_range(0, 15) == 0,
                 $urandom_range(0, 3) == 0, $urandom & 32'h0000_FF7F, "RND");
        end
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule